// File: doc/BRIEF.md
# Low-Power Wait Wake-Up Controller

This block follows a processor core through its low-power wait state. The instruction decoder presents each execution set with one flag per issue slot that marks a wait instruction. When a set carries exactly one wait, the block enters the waiting state and holds a halt output that stops core processing and gates its clocks. A set that flags more than one wait is illegal. The block reports it and does not enter the wait state.

While waiting, the block samples its wake-up sources on every clock. These are a debug-event pin, a debug-port request, a non-maskable interrupt and a maskable interrupt request with its priority. It compares the maskable priority against the status-register priority mask and the global-disable bit. On the clock edge after a qualifying condition, it returns to the run state and drops the halt output. In that same cycle it reports a one-cycle exit code: service the interrupt, resume without servicing, or enter debug.

The block never clears or acknowledges a maskable request that it leaves pending. That request stays with the interrupt controller. Asynchronous reset always returns the block to the run state.

Top module: `wait_wake_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, halt_o and exit_valid_o are 0 and exit_code_o is 0.
- R2: In the run state, a clock edge with set_valid_i high and exactly one bit of wait_flags_i set makes halt_o 1 from the next cycle.
- R3: While set_valid_i is high and two or more bits of wait_flags_i are set, illegal_o is 1 in that same cycle, and the block stays in the run state. illegal_o is 0 at all other times.
- R4: While waiting with no wake condition present, halt_o stays 1, exit_valid_o stays 0, and set_valid_i and wait_flags_i have no effect.
- R5: While waiting, dbg_evt_i or dbg_port_req_i high at an edge gives, in the next cycle, halt_o 0, exit_valid_o 1 and exit_code_o 3 (debug). Debug takes precedence over every interrupt input.
- R6: While waiting with no debug request, nmi_i high at an edge gives, in the next cycle, halt_o 0, exit_valid_o 1 and exit_code_o 1 (service). The mask and the disable bit have no effect on this.
- R7: While waiting with no debug or non-maskable request, irq_req_i with irq_prio_i > sr_ipl_i (unsigned) and sr_di_i 0 gives exit code 1 (service) in the next cycle, with halt_o 0.
- R8: In the same situation but with sr_di_i 1, the exit code is 2 (resume) in the next cycle, with halt_o 0.
- R9: A maskable request with irq_prio_i <= sr_ipl_i leaves the block waiting. This holds for priority 7 against mask 7 as well.
- R10: exit_valid_o is high for exactly one cycle per exit. exit_code_o is 0 whenever exit_valid_o is 0.
- R11: Pulling rst_ni low while waiting returns the block to the run state with halt_o 0 and no exit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_valid_i | input | 1 | Decoded execution set is presented this cycle |
| wait_flags_i | input | SLOTS | One bit per slot that holds a wait instruction |
| irq_req_i | input | 1 | Maskable interrupt request |
| irq_prio_i | input | PRIO_W | Priority of the maskable request |
| nmi_i | input | 1 | Non-maskable interrupt |
| dbg_evt_i | input | 1 | External debug-event pin |
| dbg_port_req_i | input | 1 | Debug-port halt request |
| sr_ipl_i | input | PRIO_W | Status-register priority mask |
| sr_di_i | input | 1 | Status-register global interrupt disable |
| halt_o | output | 1 | Core halt / clock gate, high while waiting |
| exit_valid_o | output | 1 | One-cycle strobe, an exit code is reported |
| exit_code_o | output | 2 | 1 service, 2 resume, 3 debug, 0 none |
| illegal_o | output | 1 | Execution set flags more than one wait |

## Verification
The bench uses the defaults: six issue slots and 3-bit priorities. With these values every mask/priority pair can be reached, including equal values and the 7-against-7 case. Set patterns with zero, one and several wait flags are easy to produce at random. Random cycles are weighted so that waits last several cycles. Competing wake sources therefore often arrive together, which exercises the debug, non-maskable and maskable precedence. Directed cases add equal priority with the disable bit set and a reset taken in mid-wait.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
  typedef enum logic [1:0] {
    EXIT_NONE    = 2'd0,
    EXIT_SERVICE = 2'd1,
    EXIT_RESUME  = 2'd2,
    EXIT_DEBUG   = 2'd3
  } exit_e;
endpackage

// File: rtl/wwc_slot_check.sv
module wwc_slot_check #(
  parameter int unsigned SLOTS = 6
) (
  input  logic             set_valid_i,
  input  logic [SLOTS-1:0] wait_flags_i,
  output logic             single_o,
  output logic             multi_o
);
  localparam int unsigned CW = $clog2(SLOTS + 1);

  logic [CW-1:0] psum [SLOTS+1];
  assign psum[0] = '0;

  for (genvar i = 0; i < SLOTS; i++) begin : g_cnt
    assign psum[i+1] = psum[i] + CW'(wait_flags_i[i]);
  end

  assign single_o = set_valid_i && (psum[SLOTS] == CW'(1));
  assign multi_o  = set_valid_i && (psum[SLOTS] > CW'(1));
endmodule

// File: rtl/wwc_wake_arb.sv
module wwc_wake_arb
  import wwc_pkg::*;
#(
  parameter int unsigned PRIO_W = 3
) (
  input  logic              dbg_evt_i,
  input  logic              dbg_port_req_i,
  input  logic              nmi_i,
  input  logic              irq_req_i,
  input  logic [PRIO_W-1:0] irq_prio_i,
  input  logic [PRIO_W-1:0] sr_ipl_i,
  input  logic              sr_di_i,
  output logic              wake_o,
  output exit_e             code_o
);
  logic irq_above;
  assign irq_above = irq_req_i && (irq_prio_i > sr_ipl_i);

  always_comb begin
    wake_o = 1'b1;
    code_o = EXIT_NONE;
    if (dbg_evt_i || dbg_port_req_i) code_o = EXIT_DEBUG;
    else if (nmi_i)                  code_o = EXIT_SERVICE;
    else if (irq_above)              code_o = sr_di_i ? EXIT_RESUME : EXIT_SERVICE;
    else                             wake_o = 1'b0;
  end
endmodule

// File: rtl/wait_wake_ctrl.sv
module wait_wake_ctrl
  import wwc_pkg::*;
#(
  parameter int unsigned SLOTS  = 6,
  parameter int unsigned PRIO_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_valid_i,
  input  logic [SLOTS-1:0]  wait_flags_i,
  input  logic              irq_req_i,
  input  logic [PRIO_W-1:0] irq_prio_i,
  input  logic              nmi_i,
  input  logic              dbg_evt_i,
  input  logic              dbg_port_req_i,
  input  logic [PRIO_W-1:0] sr_ipl_i,
  input  logic              sr_di_i,
  output logic              halt_o,
  output logic              exit_valid_o,
  output logic [1:0]        exit_code_o,
  output logic              illegal_o
);
  logic  single_wait, multi_wait, wake;
  exit_e wake_code;
  logic  waiting_q, exit_valid_q;
  exit_e exit_code_q;

  wwc_slot_check #(.SLOTS(SLOTS)) i_slot_check (
    .set_valid_i (set_valid_i),
    .wait_flags_i(wait_flags_i),
    .single_o    (single_wait),
    .multi_o     (multi_wait)
  );

  wwc_wake_arb #(.PRIO_W(PRIO_W)) i_wake_arb (
    .dbg_evt_i     (dbg_evt_i),
    .dbg_port_req_i(dbg_port_req_i),
    .nmi_i         (nmi_i),
    .irq_req_i     (irq_req_i),
    .irq_prio_i    (irq_prio_i),
    .sr_ipl_i      (sr_ipl_i),
    .sr_di_i       (sr_di_i),
    .wake_o        (wake),
    .code_o        (wake_code)
  );

  // illegal sets are reported only from the run state
  assign illegal_o = multi_wait && !waiting_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q    <= 1'b0;
      exit_valid_q <= 1'b0;
      exit_code_q  <= EXIT_NONE;
    end else if (waiting_q) begin
      waiting_q    <= !wake;
      exit_valid_q <= wake;
      exit_code_q  <= wake ? wake_code : EXIT_NONE;
    end else begin
      waiting_q    <= single_wait;
      exit_valid_q <= 1'b0;
      exit_code_q  <= EXIT_NONE;
    end
  end

  assign halt_o       = waiting_q;
  assign exit_valid_o = exit_valid_q;
  assign exit_code_o  = exit_code_q;

  assert_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && set_valid_i && $countones(wait_flags_i) == 1) |=> halt_o);

  assert_illegal_no_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && illegal_o) |=> !halt_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !dbg_evt_i && !dbg_port_req_i && !nmi_i && !irq_req_i) |=> (halt_o && !exit_valid_o));

  assert_debug_exit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && (dbg_evt_i || dbg_port_req_i)) |=> (!halt_o && exit_valid_o && exit_code_o == 2'd3));

  assert_nmi_exit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !dbg_evt_i && !dbg_port_req_i && nmi_i) |=> (exit_valid_o && exit_code_o == 2'd1));

  assert_resume_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !dbg_evt_i && !dbg_port_req_i && !nmi_i && irq_req_i && irq_prio_i > sr_ipl_i && sr_di_i)
    |=> (exit_valid_o && exit_code_o == 2'd2));

  assert_masked_stay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !dbg_evt_i && !dbg_port_req_i && !nmi_i && irq_prio_i <= sr_ipl_i) |=> halt_o);

  assert_single_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_valid_o |=> !exit_valid_o);

  assert_strobe_from_wait_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_valid_o |-> (!halt_o && $past(halt_o)));

  assert_code_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exit_valid_o |-> exit_code_o == 2'd0);
endmodule

// File: tb/test_wait_wake_ctrl.sv
`timescale 1ns/1ps
module test_wait_wake_ctrl;
  localparam int SLOTS  = 6;
  localparam int PRIO_W = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              set_valid_i = 1'b0;
  logic [SLOTS-1:0]  wait_flags_i = '0;
  logic              irq_req_i = 1'b0;
  logic [PRIO_W-1:0] irq_prio_i = '0;
  logic              nmi_i = 1'b0;
  logic              dbg_evt_i = 1'b0;
  logic              dbg_port_req_i = 1'b0;
  logic [PRIO_W-1:0] sr_ipl_i = '0;
  logic              sr_di_i = 1'b0;
  logic              halt_o, exit_valid_o, illegal_o;
  logic [1:0]        exit_code_o;

  int n_chk = 0;
  int n_fail = 0;
  logic exp_wait = 1'b0;

  always #5 clk_i = ~clk_i;

  wait_wake_ctrl #(.SLOTS(SLOTS), .PRIO_W(PRIO_W)) i_wait_wake_ctrl (
    .clk_i, .rst_ni, .set_valid_i, .wait_flags_i, .irq_req_i, .irq_prio_i,
    .nmi_i, .dbg_evt_i, .dbg_port_req_i, .sr_ipl_i, .sr_di_i,
    .halt_o, .exit_valid_o, .exit_code_o, .illegal_o
  );

  // {next_wait, valid, code[1:0]}
  function automatic logic [3:0] model(input logic w);
    if (!w) return {(set_valid_i && $countones(wait_flags_i) == 1), 3'b000};
    if (dbg_evt_i || dbg_port_req_i) return 4'b0111;
    if (nmi_i) return 4'b0101;
    if (irq_req_i && irq_prio_i > sr_ipl_i) return sr_di_i ? 4'b0110 : 4'b0101;
    return 4'b1000;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic w);
    if (!w) return "R2";
    if (dbg_evt_i || dbg_port_req_i) return "R5";
    if (nmi_i) return "R6";
    if (irq_req_i && irq_prio_i > sr_ipl_i) return sr_di_i ? "R8" : "R7";
    if (irq_req_i) return "R9";
    return "R4";
  endfunction

  // inputs already driven after negedge; check illegal, clock, check outputs
  task automatic step();
    logic [3:0] e;
    string t;
    #1;
    chk("R3 illegal", {3'b0, illegal_o},
        {3'b0, (!exp_wait && set_valid_i && $countones(wait_flags_i) > 1)});
    e = model(exp_wait);
    t = tag_of(exp_wait);
    @(posedge clk_i); #2;
    exp_wait = e[3];
    chk({t, " halt/exit"}, {halt_o, exit_valid_o, exit_code_o}, e);
    chk("R10 code idle", {3'b0, (!exit_valid_o && exit_code_o != 2'd0)}, 4'b0);
    @(negedge clk_i);
  endtask

  task automatic idle_inputs();
    set_valid_i = 0; wait_flags_i = '0; irq_req_i = 0; irq_prio_i = '0;
    nmi_i = 0; dbg_evt_i = 0; dbg_port_req_i = 0; sr_ipl_i = '0; sr_di_i = 0;
  endtask

  task automatic enter_wait();
    idle_inputs(); set_valid_i = 1; wait_flags_i = 6'b000100; step();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1295));
    repeat (3) @(negedge clk_i);
    chk("R1 reset", {halt_o, exit_valid_o, exit_code_o}, 4'b0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 after reset", {halt_o, exit_valid_o, exit_code_o}, 4'b0);

    // R3 directed: two waits, no entry
    set_valid_i = 1; wait_flags_i = 6'b100001; step();
    // R2 entry, R4 new set ignored while waiting
    enter_wait();
    set_valid_i = 1; wait_flags_i = 6'b000011; step();
    // R9 prio 7 vs mask 7, disable set
    idle_inputs(); irq_req_i = 1; irq_prio_i = 3'd7; sr_ipl_i = 3'd7; sr_di_i = 1; step();
    // R8 resume
    irq_prio_i = 3'd7; sr_ipl_i = 3'd6; step();
    // R6 nmi overrides full mask
    enter_wait();
    idle_inputs(); nmi_i = 1; sr_ipl_i = 3'd7; sr_di_i = 1; step();
    // R5 debug beats nmi and irq
    enter_wait();
    idle_inputs(); dbg_port_req_i = 1; nmi_i = 1; irq_req_i = 1; irq_prio_i = 3'd5; step();
    // R7 service
    enter_wait();
    idle_inputs(); irq_req_i = 1; irq_prio_i = 3'd4; sr_ipl_i = 3'd3; step();
    // R11 reset mid-wait
    enter_wait();
    idle_inputs();
    rst_ni = 0; #1;
    chk("R11 reset in wait", {halt_o, exit_valid_o, exit_code_o}, 4'b0);
    exp_wait = 0;
    @(negedge clk_i); rst_ni = 1; @(negedge clk_i);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      set_valid_i    = r[0];
      wait_flags_i   = (r[3:1] == 3'd0) ? 6'(1 << (r[7:4] % SLOTS)) : 6'(r[13:8]) & 6'(r[19:14]);
      irq_req_i      = r[20];
      irq_prio_i     = r[23:21];
      sr_ipl_i       = r[26:24];
      sr_di_i        = r[27];
      nmi_i          = (r[31:28] == 4'd0);
      dbg_evt_i      = ($urandom % 40) == 0;
      dbg_port_req_i = ($urandom % 40) == 0;
      step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule